// File: doc/BRIEF.md
# Keyed Lock-In Watchdog Timer

This block is a watchdog built around a 64-bit up-counter. Software turns it on through a small register write port: it selects the watchdog mode in a control register and sets an enable bit. From that moment the block is locked in watchdog operation. Further control writes are dropped, and only the synchronous reset returns it to the idle state.

While active, the counter advances by one every clock. Software keeps it from expiring by writing a two-step key sequence into a 16-bit key register. An arming key must come first, and a firing key second. Only that ordered pair returns the counter to zero. Any other key value written between the two cancels the arming.

If the counter reaches the 64-bit period, the block raises a one-cycle timeout pulse and sets a sticky timeout flag. The flag stays set until software clears it by writing 1 to it. Generating the actual system reset from the pulse is left to the surrounding logic.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, `count_o` is 0, and `flag_o`, `timeout_o`, `active_o`, `wd_en_o` and `mode_o` are all 0. The period resets to all ones.
- R2: The control register sits at address 0, with the mode in data bits [1:0] and the enable in bit 4. `active_o` rises on the edge that accepts a control write leaving the mode at 2 with the enable set. No other mode/enable combination activates the block.
- R3: Once `active_o` is 1, control writes leave `mode_o` and `wd_en_o` unchanged, and `active_o` stays 1, until reset.
- R4: While inactive, the counter holds at 0. While active, it increments by one per clock across the full 64-bit width.
- R5: Servicing uses the key register at address 3, data bits [15:0]. A write of `ARM_KEY` (default 16'hA5C6) arms the block. A later write of `FIRE_KEY` (default 16'hDA7E) while armed clears the counter to 0 on that edge and disarms. A firing key written while not armed has no effect. Writes to other addresses do not cancel the arming.
- R6: The period is written at address 1 (low 32 bits) and address 2 (high 32 bits). When the counter equals the full 64-bit period, the next edge does three things: it clears the counter to 0, it drives `timeout_o` high for exactly one cycle, and it sets `flag_o`.
- R7: `flag_o` is sticky. A write of 1 to data bit 0 at address 4 clears it. Writing 0 there has no effect. A timeout on the same edge wins over the clear.
- R8: Key writes made while the block is inactive neither arm it nor touch the counter.
- R9: Any key value other than `ARM_KEY` written while armed cancels the arming, so a following `FIRE_KEY` does not clear the counter.
- R10: A service on the same edge as a period match wins. The counter returns to 0, and neither `timeout_o` nor `flag_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 period low, 2 period high, 3 key, 4 status) |
| wr_data | input | 32 | Write data |
| mode_o | output | 2 | Current mode field |
| wd_en_o | output | 1 | Current enable bit |
| active_o | output | 1 | Watchdog operation locked on |
| count_o | output | 64 | Counter value |
| flag_o | output | 1 | Sticky timeout flag |
| timeout_o | output | 1 | One-cycle timeout pulse |

## Verification
The bench attacks the edges of the key sequence: a firing key with no arming, an arming key sent before activation, and a stray key value between the two steps. A design with a loose arming latch would clear the counter in each case, and the count then falls behind the model.

It also lands a firing key exactly on the cycle the counter matches the period. A design that lets the match win would raise a spurious timeout there. It tries to rewrite the mode after lock-in, which a missing lock would let through. Finally, it sets a period whose high half is nonzero, where a design that compared only the low half would time out early.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_PRD_LO = 3'd1,
    A_PRD_HI = 3'd2,
    A_KEY    = 3'd3,
    A_STAT   = 3'd4
  } reg_addr_e;

  localparam int          ADDR_W    = 3;
  localparam logic [1:0]  MODE_WDOG = 2'd2;
  localparam int          EN_BIT    = 4;
  localparam int          CLR_BIT   = 0;
endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import kwdt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        mode_q,
  output logic              en_q,
  output logic              active_q,
  output logic [CNT_W-1:0]  prd_q
);
  logic [1:0] mode_nx;
  logic       en_nx;

  // control fields freeze once lock-in happened
  always_comb begin
    mode_nx = mode_q;
    en_nx   = en_q;
    if (wr_en && wr_addr == A_CTRL && !active_q) begin
      mode_nx = wr_data[1:0];
      en_nx   = wr_data[EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      en_q     <= 1'b0;
      active_q <= 1'b0;
    end else begin
      mode_q   <= mode_nx;
      en_q     <= en_nx;
      active_q <= active_q | ((mode_nx == MODE_WDOG) && en_nx);
    end
  end

  // one write window per period half
  for (genvar h = 0; h < 2; h++) begin : g_prd
    always_ff @(posedge clk) begin
      if (rst)
        prd_q[h*DATA_W +: DATA_W] <= '1;
      else if (wr_en && wr_addr == ADDR_W'(A_PRD_LO + h))
        prd_q[h*DATA_W +: DATA_W] <= wr_data;
    end
  end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq #(
  parameter int               KEY_W    = 16,
  parameter logic [KEY_W-1:0] ARM_KEY  = 16'hA5C6,
  parameter logic [KEY_W-1:0] FIRE_KEY = 16'hDA7E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  output logic             svc
);
  logic armed_q;

  assign svc = key_wr && active && armed_q && (key_val == FIRE_KEY);

  // every key write re-decides the arming; only the arm key while active keeps it
  always_ff @(posedge clk) begin
    if (rst)
      armed_q <= 1'b0;
    else if (key_wr)
      armed_q <= active && (key_val == ARM_KEY);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             svc,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             tmo_q
);
  logic match;
  logic expire;

  assign match  = (cnt_q == prd);
  assign expire = active && !svc && match;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      tmo_q <= expire;
      if (!active || svc || match)
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
      if (expire)
        flag_q <= 1'b1;
      else if (flag_clr)
        flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int               DATA_W   = 32,
  parameter int               KEY_W    = 16,
  parameter logic [KEY_W-1:0] ARM_KEY  = 16'hA5C6,
  parameter logic [KEY_W-1:0] FIRE_KEY = 16'hDA7E,
  localparam int              CNT_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        mode_o,
  output logic              wd_en_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              flag_o,
  output logic              timeout_o
);
  logic [CNT_W-1:0] prd;
  logic             svc;
  logic             key_wr;
  logic             flag_clr;

  assign key_wr   = wr_en && wr_addr == A_KEY;
  assign flag_clr = wr_en && wr_addr == A_STAT && wr_data[CLR_BIT];

  wdt_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode_o), .en_q(wd_en_o), .active_q(active_o), .prd_q(prd)
  );

  wdt_keyseq #(.KEY_W(KEY_W), .ARM_KEY(ARM_KEY), .FIRE_KEY(FIRE_KEY)) u_key (
    .clk(clk), .rst(rst), .active(active_o), .key_wr(key_wr),
    .key_val(wr_data[KEY_W-1:0]), .svc(svc)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .active(active_o), .svc(svc), .flag_clr(flag_clr),
    .prd(prd), .cnt_q(count_o), .flag_q(flag_o), .tmo_q(timeout_o)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             clr_bit,
  input logic [1:0]       mode_o,
  input logic             wd_en_o,
  input logic             active_o,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o,
  input logic             timeout_o,
  input logic             svc
);
  // R2: lock-in only with the watchdog mode and the enable bit
  p_active_cfg_r2: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (mode_o == 2'd2) && wd_en_o);

  // R3: once locked, control fields and lock stay put
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (rst)
    active_o |=> active_o && $stable(mode_o) && $stable(wd_en_o));

  // R4: idle counter stays at zero
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> count_o == '0);

  // R5: an accepted service clears the counter on that edge
  p_service_clears_r5: assert property (@(posedge clk) disable iff (rst)
    svc |=> count_o == '0);

  // R6: a timeout pulse always comes with the flag and a restarted counter
  p_tmo_flag_r6: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> flag_o && count_o == '0 && active_o);

  // R7: flag stays set unless software clears it
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !(wr_en && wr_addr == 3'd4 && clr_bit)) |=> flag_o);

  // R10: a service suppresses the timeout on the same edge
  p_svc_beats_tmo_r10: assert property (@(posedge clk) disable iff (rst)
    svc |=> !timeout_o);
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .clr_bit(wr_data[0]),
  .mode_o(mode_o), .wd_en_o(wd_en_o), .active_o(active_o), .count_o(count_o),
  .flag_o(flag_o), .timeout_o(timeout_o), .svc(svc)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  localparam logic [15:0] ARM  = 16'hA5C6;
  localparam logic [15:0] FIRE = 16'hDA7E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  mode_o;
  logic        wd_en_o, active_o, flag_o, timeout_o;
  logic [63:0] count_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  keyed_wdt u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_o(mode_o), .wd_en_o(wd_en_o), .active_o(active_o), .count_o(count_o),
    .flag_o(flag_o), .timeout_o(timeout_o)
  );

  // reference model written from the requirements
  logic [1:0]  m_mode;
  logic        m_en, m_act, m_arm, m_flag, m_tmo;
  logic [63:0] m_cnt, m_prd;
  bit          m_valid = 0;

  function automatic bit is_svc(logic act, logic arm, logic we, logic [2:0] a, logic [31:0] d);
    return act && arm && we && a == 3'd3 && d[15:0] == FIRE;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode <= 0; m_en <= 0; m_act <= 0; m_arm <= 0;
      m_flag <= 0; m_tmo <= 0; m_cnt <= 0; m_prd <= '1;
      m_valid <= 1'b0;
    end else begin
      logic [1:0] nm;
      logic ne;
      bit s, hit;
      m_valid <= 1'b1;
      nm = m_mode; ne = m_en;
      if (wr_en && wr_addr == 3'd0 && !m_act) begin nm = wr_data[1:0]; ne = wr_data[4]; end
      m_mode <= nm; m_en <= ne;
      m_act <= m_act || (nm == 2'd2 && ne);
      if (wr_en && wr_addr == 3'd1) m_prd[31:0]  <= wr_data;
      if (wr_en && wr_addr == 3'd2) m_prd[63:32] <= wr_data;
      s = is_svc(m_act, m_arm, wr_en, wr_addr, wr_data);
      if (wr_en && wr_addr == 3'd3) m_arm <= m_act && wr_data[15:0] == ARM;
      hit = m_act && !s && m_cnt == m_prd;
      m_tmo <= hit;
      m_cnt <= (!m_act || s || m_cnt == m_prd) ? 64'd0 : m_cnt + 1;
      if (hit) m_flag <= 1'b1;
      else if (wr_en && wr_addr == 3'd4 && wr_data[0]) m_flag <= 1'b0;
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // continuous comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && m_valid) begin
      check(count_o == m_cnt, "R4 count", count_o, m_cnt);
      check(timeout_o == m_tmo, "R6 timeout", timeout_o, m_tmo);
      check(flag_o == m_flag, "R7 flag", flag_o, m_flag);
      check(active_o == m_act, "R3 active", active_o, m_act);
      check({mode_o, wd_en_o} == {m_mode, m_en}, "R3 ctrl", {mode_o, wd_en_o}, {m_mode, m_en});
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      finish_up();
    end
  end

  initial begin
    logic [63:0] c;
    bit seen;
    void'($urandom(32'd1234));
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(count_o == 0 && !flag_o && !timeout_o && !active_o && !wd_en_o && mode_o == 0,
          "R1 reset", {count_o[31:0], 3'b0, flag_o, timeout_o, active_o, wd_en_o, mode_o}, 0);

    wr(3'd2, 32'd0);
    wr(3'd1, 32'd30);
    // R8: arm before activation is discarded
    wr(3'd3, {16'd0, ARM});
    // R2: mode 2 without enable, and enable with mode 1, do not activate
    wr(3'd0, 32'h0000_0002);
    check(!active_o, "R2 mode only", active_o, 0);
    wr(3'd0, 32'h0000_0011);
    check(!active_o, "R2 wrong mode", active_o, 0);
    wr(3'd0, 32'h0000_0012);
    check(active_o, "R2 activate", active_o, 1);
    idle(3);
    c = count_o;
    wr(3'd3, {16'd0, FIRE});
    check(count_o == c + 1, "R8 pre-arm ignored", count_o, c + 1);
    // R3: attempts to leave the mode
    wr(3'd0, 32'h0000_0001);
    check(mode_o == 2 && wd_en_o && active_o, "R3 locked", {mode_o, wd_en_o}, 3'b101);
    // R5: arm, unrelated register write, fire
    wr(3'd3, {16'd0, ARM});
    wr(3'd4, 32'd0);
    wr(3'd3, {16'd0, FIRE});
    check(count_o == 0, "R5 service", count_o, 0);
    // R9: stray key cancels the arming
    wr(3'd3, {16'd0, ARM});
    wr(3'd3, 32'h0000_1234);
    c = count_o;
    wr(3'd3, {16'd0, FIRE});
    check(count_o == c + 1, "R9 cancel", count_o, c + 1);
    // R6: timeout at period 30
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (timeout_o) seen = 1;
    end
    check(seen && flag_o && count_o == 0, "R6 timeout", {seen, flag_o}, 2'b11);
    @(negedge clk);
    check(!timeout_o, "R6 one cycle", timeout_o, 0);
    // R7: writing 0 keeps flag, writing 1 clears it
    wr(3'd4, 32'd0);
    check(flag_o, "R7 write0", flag_o, 1);
    wr(3'd4, 32'd1);
    check(!flag_o, "R7 clear", flag_o, 0);
    // R6: high half of the period takes part in the compare
    wr(3'd2, 32'd1);
    wr(3'd1, 32'd10);
    wr(3'd3, {16'd0, ARM});
    wr(3'd3, {16'd0, FIRE});
    idle(25);
    check(!flag_o && count_o > 20, "R6 full width", count_o, 25);
    wr(3'd1, 32'd60);
    wr(3'd2, 32'd0);
    // R10: fire lands on the matching cycle
    wr(3'd3, {16'd0, ARM});
    while (count_o != 64'd60) @(negedge clk);
    wr(3'd3, {16'd0, FIRE});
    check(!timeout_o && !flag_o && count_o == 0, "R10 service wins", {timeout_o, flag_o}, 0);
    // R7: timeout wins over a clear on the same edge
    while (count_o != 64'd60) @(negedge clk);
    wr(3'd4, 32'd1);
    check(flag_o && timeout_o, "R7 set wins", flag_o, 1);

    // random phase against the model
    wr(3'd1, 32'd40);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 16;
      if (r < 4)       wr(3'd3, {16'd0, ARM});
      else if (r < 6)  wr(3'd3, {16'd0, FIRE});
      else if (r == 6) wr(3'd3, $urandom);
      else if (r == 7) wr(3'd4, $urandom % 2);
      else if (r == 8) wr(3'd0, $urandom);
      else if (r == 9) wr(3'd1, 32'd20 + ($urandom % 40));
      else @(negedge clk);
    end

    // R1/R3: reset releases the lock
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    check(!active_o && count_o == 0 && !flag_o, "R1 re-reset", active_o, 0);
    wr(3'd0, 32'h0000_0001);
    check(mode_o == 1 && !active_o, "R3 unlocked after reset", mode_o, 1);
    idle(2);
    finish_up();
  end
endmodule